// File: doc/BRIEF.md
# Backward LMS Foreground Calibration Sequencer

This block runs the start-up calibration of a pipelined converter's digital correction. After a start pulse it first measures the converter's response to a zero reference and keeps that value as an offset. It then visits the calibration units from the back of the pipeline to the front. A unit is calibrated on the assumption that every unit behind it is already correct. For each unit the sequencer sets a reference-DAC code, puts the stage under test into doubling mode or normal mode, requests a measurement and waits for the digitized result. It then applies one least-mean-squares update to that unit's correction coefficients.

The optional shared back-end unit (index `NUM_STAGES`) needs only a linear gain term. Every front stage gets two phases. In the first phase the stage is in doubling mode and swept over a set of dc levels, and the linear and cubic terms are updated together. In the second phase the stage is in normal mode at one fixed reference, and a DAC-gain term is trained. At the end of each phase the final coefficients are written out through a single write strobe. Step size and iteration count are inputs, so firmware can trade calibration time against residual noise.

Top module: `lms_cal_sequencer`

## Requirements
- R1: After reset, `busy`, `done`, `coef_we` and `meas_req` are all 0.
- R2: The first measurement after an accepted start uses `ref_code` 0, `x2_mode` 0 and `test_stage` 0. Its result is stored as an offset `o`, and every later measurement result `m` enters the arithmetic as `d = m - o`.
- R3: Units are calibrated in descending index order. When `BACKEND_EN` is 1 the first unit is `NUM_STAGES` (the shared back end), followed by `NUM_STAGES-1` and so on down to 0. During calibration `test_stage` and `coef_stage` carry the unit index.
- R4: The first phase holds `x2_mode` at 1 and steps through `NUM_LEVELS` reference levels in this order: 0, +S, -S, +2S, -2S, and so on, where S is `LEVEL_STEP`. Each level gets N measurements, where N is `iter_count`. Each measurement is one single-cycle `meas_req` pulse, and `ref_code` is held until the result is accepted on `meas_valid`.
- R5: A unit starts with linear term `a1 = 2^FRAC` and cubic term `a3 = 0`. For each first-phase result it computes `d3 = (d*d*d) >>> CUBE_SH`, `est = (a1*d + a3*d3) >>> FRAC` and `e = est - ref`. It then updates both terms from the same `e`: `a1 -= (e*d) >>> mu_shift` and `a3 -= (e*d3) >>> mu_shift`.
- R6: The back-end unit updates only `a1`. It writes a single coefficient, with `coef_sel` 0, and skips the second phase.
- R7: The second phase holds `x2_mode` at 0 and `ref_code` at `STEP2_REF`, and makes N measurements. The DAC-gain term starts at `g = 0` and is updated as `g -= (est + g - STEP2_REF) >>> mu_shift`, using the final `a1` and `a3` from the first phase.
- R8: A front unit writes its coefficients in the order `coef_sel` 0 (`a1`), then 1 (`a3`), then 2 (`g`). Each write is a one-cycle `coef_we` pulse, and no write occurs while `busy` is 0.
- R9: `done` rises in the cycle after unit 0 writes `g`, at the same time as `busy` falls. It stays at 1 until the next accepted start and is never 1 while `busy` is 1.
- R10: A start pulse while `busy` is 1 has no effect on the measurement sequence or on the coefficients written.
- R11: An `iter_count` of 0 behaves like 1: one measurement per level and one in the second phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin calibration when idle |
| iter_count | input | IW | Measurements per level and per second phase |
| mu_shift | input | 5 | LMS step size as a right-shift amount |
| ref_code | output | DW | Signed reference-DAC code |
| test_stage | output | UW | Unit under test |
| x2_mode | output | 1 | 1: stage in doubling mode; 0: normal mode |
| meas_req | output | 1 | One-cycle request for a measurement |
| meas_valid | input | 1 | Measurement result valid |
| meas_result | input | DW | Signed digitized result |
| coef_we | output | 1 | Coefficient write strobe |
| coef_stage | output | UW | Unit of the written coefficient |
| coef_sel | output | 2 | 0 linear, 1 cubic, 2 DAC gain |
| coef_data | output | CW | Signed coefficient value |
| busy | output | 1 | Calibration in progress |
| done | output | 1 | Calibration finished |

## Verification
The bench builds the block with its defaults: three front stages plus the shared back end, four levels of step 64, a 10-bit result and 20-bit coefficients. With these settings every unit kind and every phase transition occurs within a few hundred cycles. The iteration counts 8, 3 and 0 and the shift values 10, 8 and 9 give three distinct coefficient trajectories. The zero count reaches the lower boundary of the iteration counter. The 10-bit result and the 64-step level sweep are small enough that the cubic and product terms stay within the coefficient width, so the coefficient values can be compared exactly.

// File: rtl/lms_cal_pkg.sv
package lms_cal_pkg;

   typedef enum logic [2:0] {
      ST_IDLE, ST_REQ, ST_WAIT, ST_WR_LIN, ST_WR_CUB, ST_WR_DAC
   } seq_state_t;

   typedef enum logic [1:0] {
      PH_OFFSET, PH_SWEEP, PH_DACGAIN
   } cal_phase_t;

   localparam logic [1:0] SEL_LIN = 2'd0;
   localparam logic [1:0] SEL_CUB = 2'd1;
   localparam logic [1:0] SEL_DAC = 2'd2;

   // level k: 0, +s, -s, +2s, -2s, ...
   function automatic int sweep_level(input int k, input int s);
      int mag;
      mag = ((k + 1) / 2) * s;
      if (k == 0) return 0;
      return (k % 2 == 1) ? mag : -mag;
   endfunction

endpackage

// File: rtl/cal_step_counter.sv
module cal_step_counter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   input  logic [W-1:0] limit,
   output logic [W-1:0] count,
   output logic         last
);
   logic [W-1:0] count_q;
   logic [W:0]   nxt;

   assign nxt   = {1'b0, count_q} + {{W{1'b0}}, 1'b1};
   assign last  = (nxt >= {1'b0, limit});
   assign count = count_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   count_q <= '0;
      else if (clr) count_q <= '0;
      else if (inc) count_q <= nxt[W-1:0];
   end

   // R11: the count never reaches a non-zero limit
   p_cnt_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (limit != '0) |-> (count_q < limit));

endmodule

// File: rtl/lms_coef_update.sv
module lms_coef_update #(
   parameter int DW      = 10,
   parameter int CW      = 20,
   parameter int FRAC    = 10,
   parameter int CUBE_SH = 16
) (
   input  logic signed [DW-1:0] meas,
   input  logic signed [DW-1:0] ofs,
   input  logic signed [DW-1:0] ref_lvl,
   input  logic signed [CW-1:0] a1,
   input  logic signed [CW-1:0] a3,
   input  logic signed [CW-1:0] g,
   input  logic        [4:0]    mu,
   input  logic                 lin_only,
   output logic signed [CW-1:0] a1_n,
   output logic signed [CW-1:0] a3_n,
   output logic signed [CW-1:0] g_n
);
   localparam int PW = CW + 3 * (DW + 1) + 2;

   logic signed [PW-1:0] dx, d3, a1x, a3x, gx, rx, est, e1, e2;
   logic signed [PW-1:0] a1nx, a3nx, gnx;

   assign dx  = {{(PW-DW){meas[DW-1]}}, meas} - {{(PW-DW){ofs[DW-1]}}, ofs};
   assign rx  = {{(PW-DW){ref_lvl[DW-1]}}, ref_lvl};
   assign a1x = {{(PW-CW){a1[CW-1]}}, a1};
   assign a3x = {{(PW-CW){a3[CW-1]}}, a3};
   assign gx  = {{(PW-CW){g[CW-1]}}, g};

   assign d3   = (dx * dx * dx) >>> CUBE_SH;
   assign est  = (a1x * dx + a3x * d3) >>> FRAC;
   assign e1   = est - rx;
   assign e2   = est + gx - rx;
   assign a1nx = a1x - ((e1 * dx) >>> mu);
   assign a3nx = lin_only ? a3x : (a3x - ((e1 * d3) >>> mu));
   assign gnx  = gx - (e2 >>> mu);

   assign a1_n = CW'(a1nx);
   assign a3_n = CW'(a3nx);
   assign g_n  = CW'(gnx);

endmodule

// File: rtl/lms_cal_sequencer.sv
module lms_cal_sequencer
   import lms_cal_pkg::*;
#(
   parameter int NUM_STAGES = 3,
   parameter bit BACKEND_EN = 1'b1,
   parameter int DW         = 10,
   parameter int CW         = 20,
   parameter int FRAC       = 10,
   parameter int CUBE_SH    = 16,
   parameter int IW         = 8,
   parameter int NUM_LEVELS = 4,
   parameter int LEVEL_STEP = 64,
   parameter int STEP2_REF  = 96,
   localparam int UW = $clog2(NUM_STAGES + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [IW-1:0]        iter_count,
   input  logic [4:0]           mu_shift,
   output logic signed [DW-1:0] ref_code,
   output logic [UW-1:0]        test_stage,
   output logic                 x2_mode,
   output logic                 meas_req,
   input  logic                 meas_valid,
   input  logic signed [DW-1:0] meas_result,
   output logic                 coef_we,
   output logic [UW-1:0]        coef_stage,
   output logic [1:0]           coef_sel,
   output logic signed [CW-1:0] coef_data,
   output logic                 busy,
   output logic                 done
);
   localparam int LW         = $clog2(NUM_LEVELS + 1);
   localparam int FIRST_UNIT = BACKEND_EN ? NUM_STAGES : NUM_STAGES - 1;
   localparam int MAX_LEVEL  = ((NUM_LEVELS) / 2) * LEVEL_STEP;
   localparam logic signed [CW-1:0] ONE = CW'(1 << FRAC);

   generate
      if (NUM_STAGES < 1)             $error("NUM_STAGES must be at least 1");
      if (NUM_LEVELS < 1)             $error("NUM_LEVELS must be at least 1");
      if (MAX_LEVEL >= (1 << (DW-1))) $error("level sweep exceeds DW");
      if (STEP2_REF >= (1 << (DW-1))) $error("STEP2_REF exceeds DW");
      if (CW < FRAC + 3)              $error("CW too narrow for FRAC");
   endgenerate

   seq_state_t state_q;
   cal_phase_t phase_q;
   logic [UW-1:0]        unit_q;
   logic signed [DW-1:0] ofs_q;
   logic signed [CW-1:0] a1_q, a3_q, g_q, a1_n, a3_n, g_n;
   logic                 done_q, accept, lin_only;
   logic [IW-1:0]        iter_cnt;
   logic [LW-1:0]        lvl_cnt;
   logic                 iter_last, lvl_last;
   logic                 iter_clr, iter_inc, lvl_clr, lvl_inc;

   assign accept = (state_q == ST_WAIT) && meas_valid;

   generate
      if (BACKEND_EN) begin : g_backend
         assign lin_only = (unit_q == UW'(NUM_STAGES));
      end else begin : g_no_backend
         assign lin_only = 1'b0;
      end
   endgenerate

   assign iter_clr = (state_q == ST_IDLE) || (accept && iter_last);
   assign iter_inc = accept && (phase_q != PH_OFFSET) && !iter_last;
   assign lvl_clr  = (state_q == ST_IDLE) ||
                     (accept && (phase_q == PH_SWEEP) && iter_last && lvl_last);
   assign lvl_inc  = accept && (phase_q == PH_SWEEP) && iter_last && !lvl_last;

   cal_step_counter #(.W(IW)) u_iter (
      .clk(clk), .rst_n(rst_n), .clr(iter_clr), .inc(iter_inc),
      .limit(iter_count), .count(iter_cnt), .last(iter_last));

   cal_step_counter #(.W(LW)) u_level (
      .clk(clk), .rst_n(rst_n), .clr(lvl_clr), .inc(lvl_inc),
      .limit(LW'(NUM_LEVELS)), .count(lvl_cnt), .last(lvl_last));

   always_comb begin
      unique case (phase_q)
         PH_SWEEP:   ref_code = DW'(sweep_level(int'(lvl_cnt), LEVEL_STEP));
         PH_DACGAIN: ref_code = DW'(STEP2_REF);
         default:    ref_code = '0;
      endcase
   end

   lms_coef_update #(.DW(DW), .CW(CW), .FRAC(FRAC), .CUBE_SH(CUBE_SH)) u_lms (
      .meas(meas_result), .ofs(ofs_q), .ref_lvl(ref_code),
      .a1(a1_q), .a3(a3_q), .g(g_q), .mu(mu_shift), .lin_only(lin_only),
      .a1_n(a1_n), .a3_n(a3_n), .g_n(g_n));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         phase_q <= PH_OFFSET;
         unit_q  <= '0;
         ofs_q   <= '0;
         a1_q    <= ONE;
         a3_q    <= '0;
         g_q     <= '0;
         done_q  <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (start) begin
               state_q <= ST_REQ;
               phase_q <= PH_OFFSET;
               done_q  <= 1'b0;
            end
            ST_REQ: state_q <= ST_WAIT;
            ST_WAIT: if (meas_valid) begin
               unique case (phase_q)
                  PH_OFFSET: begin
                     ofs_q   <= meas_result;
                     phase_q <= PH_SWEEP;
                     unit_q  <= UW'(FIRST_UNIT);
                     a1_q    <= ONE;
                     a3_q    <= '0;
                     g_q     <= '0;
                     state_q <= ST_REQ;
                  end
                  PH_SWEEP: begin
                     a1_q    <= a1_n;
                     a3_q    <= a3_n;
                     state_q <= (iter_last && lvl_last) ? ST_WR_LIN : ST_REQ;
                  end
                  default: begin
                     g_q     <= g_n;
                     state_q <= iter_last ? ST_WR_DAC : ST_REQ;
                  end
               endcase
            end
            ST_WR_LIN: if (lin_only) begin
               unit_q  <= unit_q - UW'(1);
               a1_q    <= ONE;
               a3_q    <= '0;
               g_q     <= '0;
               state_q <= ST_REQ;
            end else begin
               state_q <= ST_WR_CUB;
            end
            ST_WR_CUB: begin
               phase_q <= PH_DACGAIN;
               state_q <= ST_REQ;
            end
            ST_WR_DAC: if (unit_q == '0) begin
               state_q <= ST_IDLE;
               phase_q <= PH_OFFSET;
               done_q  <= 1'b1;
            end else begin
               unit_q  <= unit_q - UW'(1);
               phase_q <= PH_SWEEP;
               a1_q    <= ONE;
               a3_q    <= '0;
               g_q     <= '0;
               state_q <= ST_REQ;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy       = (state_q != ST_IDLE);
   assign done       = done_q;
   assign meas_req   = (state_q == ST_REQ);
   assign x2_mode    = (phase_q == PH_SWEEP);
   assign test_stage = (phase_q == PH_OFFSET) ? '0 : unit_q;
   assign coef_stage = unit_q;
   assign coef_we    = (state_q == ST_WR_LIN) || (state_q == ST_WR_CUB) ||
                       (state_q == ST_WR_DAC);
   always_comb begin
      unique case (state_q)
         ST_WR_CUB: begin coef_sel = SEL_CUB; coef_data = a3_q; end
         ST_WR_DAC: begin coef_sel = SEL_DAC; coef_data = g_q;  end
         default:   begin coef_sel = SEL_LIN; coef_data = a1_q; end
      endcase
   end

   // R8: writes only during a run
   p_we_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      coef_we |-> busy);
   // R9: done never overlaps busy
   p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   // R9: a run always ends with done
   p_end_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);
   // R10: start mid-run does not stop the run
   p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && !coef_we) |=> busy);
   // R4: request is a single-cycle pulse
   p_req_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      meas_req |=> !meas_req);
   // R4: reference held while the result is awaited
   p_ref_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      meas_req |=> $stable(ref_code));
   // R6: back-end unit writes only the linear term
   p_backend_lin_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (coef_we && BACKEND_EN && coef_stage == UW'(NUM_STAGES)) |-> (coef_sel == SEL_LIN));

endmodule

// File: tb/lms_cal_sequencer_test.sv
`timescale 1ns/1ps
module lms_cal_sequencer_test;
   localparam int NS = 3, DW = 10, CW = 20, FRAC = 10, CSH = 16;
   localparam int NL = 4, LSTEP = 64, REF2 = 96, UW = 2;

   logic clk = 0, rst_n = 0, start = 0, meas_valid = 0;
   logic [7:0] iter_count = 8;
   logic [4:0] mu_shift = 10;
   logic signed [DW-1:0] ref_code, meas_result = '0;
   logic [UW-1:0] test_stage, coef_stage;
   logic x2_mode, meas_req, coef_we, busy, done;
   logic [1:0] coef_sel;
   logic signed [CW-1:0] coef_data;

   int checks = 0, failures = 0, bad_done = 0;
   int m_n, w_n, e_n, ew_n;
   longint m_ref[512], m_x2[512], m_stg[512];
   longint w_stg[64], w_sel[64], w_dat[64];
   longint e_ref[512], e_x2[512], e_stg[512];
   longint ew_stg[64], ew_sel[64], ew_dat[64];
   bit pend = 0;
   longint p_ref, p_x2, p_stg;

   always #4 clk = ~clk;

   lms_cal_sequencer uut (
      .clk(clk), .rst_n(rst_n), .start(start), .iter_count(iter_count),
      .mu_shift(mu_shift), .ref_code(ref_code), .test_stage(test_stage),
      .x2_mode(x2_mode), .meas_req(meas_req), .meas_valid(meas_valid),
      .meas_result(meas_result), .coef_we(coef_we), .coef_stage(coef_stage),
      .coef_sel(coef_sel), .coef_data(coef_data), .busy(busy), .done(done));

   function automatic longint plant(longint r, longint x2, longint stg);
      if (x2 != 0) return ((r * 7) >>> 3) + ((r * r * r) >>> 18) + 5 + stg;
      return ((r * 7) >>> 3) - 35 + stg;
   endfunction

   function automatic longint lvl(int k);
      longint mag = longint'(((k + 1) / 2) * LSTEP);
      if (k == 0) return 0;
      return (k % 2 == 1) ? mag : -mag;
   endfunction

   // converter model and logging, all away from the rising edge
   always @(negedge clk) begin
      if (pend) begin
         meas_valid = 1;
         meas_result = DW'(plant(p_ref, p_x2, p_stg));
         pend = 0;
      end else meas_valid = 0;
      if (meas_req) begin
         p_ref = longint'(ref_code); p_x2 = longint'(x2_mode); p_stg = longint'(test_stage);
         if (m_n < 512) begin
            m_ref[m_n] = p_ref; m_x2[m_n] = p_x2; m_stg[m_n] = p_stg;
         end
         m_n++;
         pend = 1;
      end
      if (coef_we) begin
         if (w_n < 64) begin
            w_stg[w_n] = longint'(coef_stage); w_sel[w_n] = longint'(coef_sel);
            w_dat[w_n] = longint'(coef_data);
         end
         w_n++;
      end
      if (busy && done) bad_done++;
   end

   task automatic chk(bit ok, string req, string what, longint act, longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic add_m(longint r, longint x2, longint s);
      e_ref[e_n] = r; e_x2[e_n] = x2; e_stg[e_n] = s; e_n++;
   endtask
   task automatic add_w(longint s, longint sel, longint d);
      ew_stg[ew_n] = s; ew_sel[ew_n] = sel; ew_dat[ew_n] = d; ew_n++;
   endtask

   task automatic build_exp(int it, int mu);
      int n_it = (it == 0) ? 1 : it;
      longint ofs, a1, a3, g, d, d3, est, e, a1n;
      e_n = 0; ew_n = 0;
      add_m(0, 0, 0);
      ofs = plant(0, 0, 0);
      for (int u = NS; u >= 0; u--) begin
         a1 = 1 << FRAC; a3 = 0; g = 0;
         for (int k = 0; k < NL; k++)
            for (int i = 0; i < n_it; i++) begin
               add_m(lvl(k), 1, u);
               d = plant(lvl(k), 1, u) - ofs;
               d3 = (d * d * d) >>> CSH;
               est = (a1 * d + a3 * d3) >>> FRAC;
               e = est - lvl(k);
               a1n = a1 - ((e * d) >>> mu);
               if (u != NS) a3 = a3 - ((e * d3) >>> mu);
               a1 = a1n;
            end
         add_w(u, 0, a1);
         if (u != NS) begin
            add_w(u, 1, a3);
            for (int i = 0; i < n_it; i++) begin
               add_m(REF2, 0, u);
               d = plant(REF2, 0, u) - ofs;
               d3 = (d * d * d) >>> CSH;
               est = (a1 * d + a3 * d3) >>> FRAC;
               g = g - ((est + g - REF2) >>> mu);
            end
            add_w(u, 2, g);
         end
      end
   endtask

   // one full run; inject: extra start pulse mid-run
   task automatic run_cal(int it, int mu, string tag, bit inject);
      int t, bad;
      build_exp(it, mu);
      m_n = 0; w_n = 0; bad_done = 0;
      @(negedge clk); iter_count = 8'(it); mu_shift = 5'(mu); start = 1;
      @(negedge clk); start = 0;
      chk(done == 0 && busy == 1, "R9", {tag, " done cleared by start"}, done, 0);
      if (inject) begin
         repeat (60) @(negedge clk);
         start = 1; @(negedge clk); start = 0;
      end
      t = 0;
      while (busy && t < 20000) begin @(negedge clk); t++; end
      chk(t < 20000, "R9", {tag, " run finished"}, t, 0);
      chk(done == 1 && bad_done == 0, "R9", {tag, " done at end only"}, bad_done, 0);
      chk(w_n == ew_n && w_n > 0 && w_stg[w_n-1] == 0 && w_sel[w_n-1] == 2,
          "R9", {tag, " last write is unit 0 gain"}, w_n, ew_n);
      chk(m_n == e_n, inject ? "R10" : "R4", {tag, " measurement count"}, m_n, e_n);
      chk(m_ref[0] == 0 && m_x2[0] == 0 && m_stg[0] == 0, "R2",
          {tag, " offset measurement first"}, m_ref[0], 0);
      bad = -1;
      for (int i = 0; i < e_n && i < m_n; i++)
         if (bad < 0 && (m_ref[i] != e_ref[i] || m_x2[i] != e_x2[i] || m_stg[i] != e_stg[i])) bad = i;
      chk(bad < 0, inject ? "R10" : "R4", {tag, " level/mode/stage sequence"},
          (bad < 0) ? 0 : m_ref[bad], (bad < 0) ? 0 : e_ref[bad]);
      bad = -1;
      for (int i = 0; i < ew_n && i < w_n; i++)
         if (bad < 0 && (w_stg[i] != ew_stg[i] || w_sel[i] != ew_sel[i])) bad = i;
      chk(bad < 0, "R3", {tag, " unit order and R8 select order"},
          (bad < 0) ? 0 : w_stg[bad] * 4 + w_sel[bad], (bad < 0) ? 0 : ew_stg[bad] * 4 + ew_sel[bad]);
      chk(w_n > 0 && w_stg[0] == NS && w_sel[0] == 0 && ew_n > 1 && w_stg[1] == NS - 1,
          "R6", {tag, " back end single linear write"}, w_stg[1], NS - 1);
      bad = -1;
      for (int i = 0; i < ew_n && i < w_n; i++)
         if (bad < 0 && ew_sel[i] != 2 && w_dat[i] != ew_dat[i]) bad = i;
      chk(bad < 0, "R5", {tag, " linear/cubic values"},
          (bad < 0) ? 0 : w_dat[bad], (bad < 0) ? 0 : ew_dat[bad]);
      bad = -1;
      for (int i = 0; i < ew_n && i < w_n; i++)
         if (bad < 0 && ew_sel[i] == 2 && w_dat[i] != ew_dat[i]) bad = i;
      chk(bad < 0, "R7", {tag, " DAC gain values"},
          (bad < 0) ? 0 : w_dat[bad], (bad < 0) ? 0 : ew_dat[bad]);
   endtask

   task automatic t_reset;
      chk(busy == 0 && done == 0 && coef_we == 0 && meas_req == 0, "R1",
          "reset outputs", {busy, done, coef_we, meas_req}, 0);
   endtask

   task automatic t_done_hold;
      repeat (20) @(negedge clk);
      chk(done == 1 && busy == 0 && coef_we == 0, "R9", "done holds while idle", done, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1;
      @(negedge clk);
      t_reset();
      run_cal(8, 10, "base", 0);
      t_done_hold();
      run_cal(3, 8, "start_mid_run", 1);
      run_cal(0, 9, "iter_zero_R11", 0);
      chk(m_n == 1 + NL + NS * (NL + 1), "R11", "one measurement per step", m_n, 1 + NL + NS * (NL + 1));
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      checks++;
      $display("FAIL watchdog R9 actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule